// File: doc/BRIEF.md
# Full-configuration camera link framing decoder

This block sits behind the deserializers of a three-channel, 28-bit-per-channel camera link receiver running in the Full configuration. On each pixel clock it takes the channel X, Y and Z words and recovers the line, frame and data valid framing signals. It corrects their polarity and emits a registered strobe that carries eight 8-bit pixels. Alongside the strobe it produces frame and line boundary pulses and the position of each beat within its line and frame.

Runtime inputs select the polarity of each framing signal independently. A further input drops the data-valid term for cameras that do not drive it, so that beats are qualified by frame and line valid only. Channel X is the reference for framing. A sticky error flag reports any beat on which the framing bits of channel Y or Z disagree with channel X.

Top module: `cl_full_framer`

## Requirements
- R1: The framing bits of a channel word are: bit 24 line valid, bit 25 frame valid, bit 26 data valid, taken from channel X. Each bit is XORed with its own invert input (`inv_lval_i`, `inv_fval_i`, `inv_dval_i`; 1 means the wire is active low) to give the normalised signal.
- R2: `pix_valid_o` is high in the cycle after a beat whose normalised frame and line valid are both 1, and whose normalised data valid is 1 or `use_dval_i` is 0. It is low after any other beat.
- R3: Each channel carries pixel data on bits 23..0. These bits are packed as {Z[23:0], Y[23:0], X[23:0]}, and pixel k is bits 8k+7..8k of that pool, placed at `pix_data_o[8k+7:8k]`. The data appears with one cycle of latency together with `pix_valid_o` and holds its value after unqualified beats.
- R4: `sof_o` pulses for one cycle after the beat on which normalised frame valid rises. `eof_o` pulses for one cycle after the beat on which it falls.
- R5: `sol_o` pulses after a beat where line valid rises while frame valid is 1 on that beat. `eol_o` pulses after a beat where line valid falls and frame valid was 1 on the previous beat. A line valid edge outside a frame gives no pulse.
- R6: `pix_cnt_o` gives the 0-based index of the current qualified beat within its line, output with `pix_valid_o`. It restarts at 0 on each line valid rise.
- R7: `line_cnt_o` counts the lines completed in the current frame. It is 0 from the frame start pulse and increments together with each `eol_o`.
- R8: `sync_err_o` is set in the cycle after a qualified beat on which the framing bits 26..24 of channel Y or Z differ from channel X. It stays set until reset. Mismatches on unqualified beats are ignored.
- R9: While `rst_ni` is low, every output is 0.
- R10: With `use_dval_i` at 0, the value of the data valid bit has no effect on qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_x_i | input | 28 | Channel X parallel word (framing reference) |
| chan_y_i | input | 28 | Channel Y parallel word |
| chan_z_i | input | 28 | Channel Z parallel word |
| use_dval_i | input | 1 | 1: data valid takes part in qualification |
| inv_lval_i | input | 1 | Invert line valid |
| inv_fval_i | input | 1 | Invert frame valid |
| inv_dval_i | input | 1 | Invert data valid |
| pix_valid_o | output | 1 | Qualified beat strobe |
| pix_data_o | output | 64 | Eight 8-bit pixels |
| sof_o | output | 1 | Frame start pulse |
| eof_o | output | 1 | Frame end pulse |
| sol_o | output | 1 | Line start pulse |
| eol_o | output | 1 | Line end pulse |
| pix_cnt_o | output | 16 | Beat index within line |
| line_cnt_o | output | 16 | Completed lines in frame |
| sync_err_o | output | 1 | Sticky channel framing mismatch |

## Verification
A table walks each polarity setting against raw framing levels and the data valid option. Any inversion applied to the wrong signal shows up as a missed or spurious strobe. A directed frame inserts a data valid gap inside a line, ends the frame and its last line on the same beat, and toggles line valid outside a frame. A design that counts gaps as pixels, drops the final line end, or reports lines outside frames is caught on those beats. Channel mismatches are driven first on an unqualified beat and then on a qualified one, so a flag that ignores qualification or is not sticky is exposed.

// File: rtl/cl_full_pkg.sv
package cl_full_pkg;
  localparam int CH_W     = 28;
  localparam int DATA_W   = 24;
  localparam int LVAL_BIT = 24;
  localparam int FVAL_BIT = 25;
  localparam int DVAL_BIT = 26;

  typedef struct packed {
    logic dv;
    logic fv;
    logic lv;
  } frame_bits_t;
endpackage

// File: rtl/cl_frame_extract.sv
module cl_frame_extract
  import cl_full_pkg::*;
(
  input  logic [CH_W-1:0] chan_x_i,
  input  logic [CH_W-1:0] chan_y_i,
  input  logic [CH_W-1:0] chan_z_i,
  input  logic            use_dval_i,
  input  logic            inv_lval_i,
  input  logic            inv_fval_i,
  input  logic            inv_dval_i,
  output frame_bits_t     norm_o,
  output logic            qual_o,
  output logic            mismatch_o
);
  frame_bits_t raw_x, raw_y, raw_z;

  always_comb begin
    raw_x = '{dv: chan_x_i[DVAL_BIT], fv: chan_x_i[FVAL_BIT], lv: chan_x_i[LVAL_BIT]};
    raw_y = '{dv: chan_y_i[DVAL_BIT], fv: chan_y_i[FVAL_BIT], lv: chan_y_i[LVAL_BIT]};
    raw_z = '{dv: chan_z_i[DVAL_BIT], fv: chan_z_i[FVAL_BIT], lv: chan_z_i[LVAL_BIT]};
    norm_o.dv = raw_x.dv ^ inv_dval_i;
    norm_o.fv = raw_x.fv ^ inv_fval_i;
    norm_o.lv = raw_x.lv ^ inv_lval_i;
    qual_o     = norm_o.fv & norm_o.lv & (norm_o.dv | ~use_dval_i);
    mismatch_o = qual_o & ((raw_y != raw_x) | (raw_z != raw_x));
  end
endmodule

// File: rtl/cl_pixel_unpack.sv
module cl_pixel_unpack
  import cl_full_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int NUM_PIX = 8,
  localparam int BUS_W  = PIX_W * NUM_PIX,
  localparam int POOL_W = 3 * DATA_W
) (
  input  logic [CH_W-1:0]  chan_x_i,
  input  logic [CH_W-1:0]  chan_y_i,
  input  logic [CH_W-1:0]  chan_z_i,
  output logic [BUS_W-1:0] pix_o
);
  logic [POOL_W-1:0] pool;
  assign pool = {chan_z_i[DATA_W-1:0], chan_y_i[DATA_W-1:0], chan_x_i[DATA_W-1:0]};

  for (genvar g = 0; g < NUM_PIX; g++) begin : g_pix
    assign pix_o[g*PIX_W +: PIX_W] = pool[g*PIX_W +: PIX_W];
  end
endmodule

// File: rtl/cl_line_tracker.sv
module cl_line_tracker
  import cl_full_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_bits_t      norm_i,
  input  logic             qual_i,
  output logic             sof_o,
  output logic             eof_o,
  output logic             sol_o,
  output logic             eol_o,
  output logic [CNT_W-1:0] pix_cnt_o,
  output logic [CNT_W-1:0] line_cnt_o
);
  logic             fv_q, lv_q;
  logic [CNT_W-1:0] beat_q;
  logic             f_rise, f_fall, l_rise, l_end;
  logic [CNT_W-1:0] idx;

  always_comb begin
    f_rise = norm_i.fv & ~fv_q;
    f_fall = ~norm_i.fv & fv_q;
    l_rise = norm_i.lv & ~lv_q;
    l_end  = lv_q & ~norm_i.lv & fv_q;
    idx    = l_rise ? '0 : beat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_q       <= 1'b0;
      lv_q       <= 1'b0;
      beat_q     <= '0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;
      sol_o      <= 1'b0;
      eol_o      <= 1'b0;
      pix_cnt_o  <= '0;
      line_cnt_o <= '0;
    end else begin
      fv_q  <= norm_i.fv;
      lv_q  <= norm_i.lv;
      sof_o <= f_rise;
      eof_o <= f_fall;
      sol_o <= l_rise & norm_i.fv;
      eol_o <= l_end;
      if (qual_i) begin
        pix_cnt_o <= idx;
        beat_q    <= idx + 1'b1;
      end else if (l_rise) begin
        beat_q <= '0;
      end
      // frame start wins over a line end on the same beat
      if (f_rise)     line_cnt_o <= '0;
      else if (l_end) line_cnt_o <= line_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/cl_full_framer.sv
module cl_full_framer
  import cl_full_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int NUM_PIX = 8,
  parameter int CNT_W   = 16,
  localparam int BUS_W  = PIX_W * NUM_PIX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_W-1:0]  chan_x_i,
  input  logic [CH_W-1:0]  chan_y_i,
  input  logic [CH_W-1:0]  chan_z_i,
  input  logic             use_dval_i,
  input  logic             inv_lval_i,
  input  logic             inv_fval_i,
  input  logic             inv_dval_i,
  output logic             pix_valid_o,
  output logic [BUS_W-1:0] pix_data_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             sol_o,
  output logic             eol_o,
  output logic [CNT_W-1:0] pix_cnt_o,
  output logic [CNT_W-1:0] line_cnt_o,
  output logic             sync_err_o
);
  frame_bits_t      norm;
  logic             qual, mismatch;
  logic [BUS_W-1:0] pix_w;

  cl_frame_extract u_extract (
    .chan_x_i   (chan_x_i),
    .chan_y_i   (chan_y_i),
    .chan_z_i   (chan_z_i),
    .use_dval_i (use_dval_i),
    .inv_lval_i (inv_lval_i),
    .inv_fval_i (inv_fval_i),
    .inv_dval_i (inv_dval_i),
    .norm_o     (norm),
    .qual_o     (qual),
    .mismatch_o (mismatch)
  );

  cl_pixel_unpack #(.PIX_W(PIX_W), .NUM_PIX(NUM_PIX)) u_unpack (
    .chan_x_i (chan_x_i),
    .chan_y_i (chan_y_i),
    .chan_z_i (chan_z_i),
    .pix_o    (pix_w)
  );

  cl_line_tracker #(.CNT_W(CNT_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .norm_i     (norm),
    .qual_i     (qual),
    .sof_o      (sof_o),
    .eof_o      (eof_o),
    .sol_o      (sol_o),
    .eol_o      (eol_o),
    .pix_cnt_o  (pix_cnt_o),
    .line_cnt_o (line_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      sync_err_o  <= 1'b0;
    end else begin
      pix_valid_o <= qual;
      if (qual) pix_data_o <= pix_w;
      if (mismatch) sync_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cl_full_framer_chk.sv
module cl_full_framer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_o,
  input logic             sof_o,
  input logic             eof_o,
  input logic             sol_o,
  input logic             eol_o,
  input logic [CNT_W-1:0] pix_cnt_o,
  input logic [CNT_W-1:0] line_cnt_o,
  input logic             sync_err_o
);
  // R4
  frame_edges_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sof_o && eof_o));

  // R8
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |=> sync_err_o);

  // R6
  line_first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_o && pix_valid_o) |-> (pix_cnt_o == '0));

  // R7
  frame_line_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (line_cnt_o == '0));

  // R7
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_o && !sof_o) |-> (line_cnt_o == CNT_W'($past(line_cnt_o) + 1'b1)));

  // R5
  line_edges_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sol_o && eol_o));
endmodule

bind cl_full_framer cl_full_framer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cl_full_framer.sv
module sim_cl_full_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] cx = '0, cy = '0, cz = '0;
  logic        use_d = 1'b1, inv_l = 1'b0, inv_f = 1'b0, inv_d = 1'b0;
  logic        vld, sof, eof, sol, eol, serr;
  logic [63:0] pix;
  logic [15:0] pcnt, lcnt;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cl_full_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_x_i(cx), .chan_y_i(cy), .chan_z_i(cz),
    .use_dval_i(use_d), .inv_lval_i(inv_l), .inv_fval_i(inv_f), .inv_dval_i(inv_d),
    .pix_valid_o(vld), .pix_data_o(pix), .sof_o(sof), .eof_o(eof), .sol_o(sol),
    .eol_o(eol), .pix_cnt_o(pcnt), .line_cnt_o(lcnt), .sync_err_o(serr)
  );

  // {inv_f, inv_l, inv_d, use_d, raw_f, raw_l, raw_d, exp_valid}
  localparam logic [7:0] VEC [14] = '{
    8'b0001_1111, 8'b0001_1100, 8'b0000_1101, 8'b0001_0110,
    8'b0001_1010, 8'b1001_0111, 8'b1001_1110, 8'b0101_1011,
    8'b0011_1101, 8'b0011_1110, 8'b1111_0001, 8'b1110_0011,
    8'b1100_0011, 8'b0000_0110
  };

  function automatic logic [27:0] word(logic f, logic l, logic d, logic [23:0] dat);
    return {1'b0, d, f, l, dat};
  endfunction

  function automatic logic [63:0] exp_pix(logic [27:0] x, logic [27:0] y, logic [27:0] z);
    logic [71:0] p;
    p = {z[23:0], y[23:0], x[23:0]};
    return p[63:0];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [27:0] x, logic [27:0] y, logic [27:0] z);
    cx = x; cy = y; cz = z;
    @(posedge clk); #1;
  endtask

  task automatic step3(logic [27:0] w);
    step(w, w, w);
  endtask

  task automatic marks(string req, logic e_sof, logic e_eof, logic e_sol, logic e_eol);
    check({req, " sof"}, 64'(sof), 64'(e_sof));
    check({req, " eof"}, 64'(eof), 64'(e_eof));
    check({req, " sol"}, 64'(sol), 64'(e_sol));
    check({req, " eol"}, 64'(eol), 64'(e_eol));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [27:0] wa, wb, wc, wd;
    #2;
    // R9 reset state
    check("R9 valid", 64'(vld), 0);
    check("R9 data", pix, 0);
    check("R9 counters", {32'(pcnt), 32'(lcnt)}, 0);
    check("R9 flags", {59'd0, sof, eof, sol, eol, serr}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 R2 R10: polarity and qualification table
    for (int i = 0; i < 14; i++) begin
      logic [7:0] v;
      logic [27:0] x, y, z;
      v = VEC[i];
      {inv_f, inv_l, inv_d, use_d} = v[7:4];
      x = word(v[3], v[2], v[1], {8'(i), 8'(3*i+1), 8'(5*i+2)});
      y = word(v[3], v[2], v[1], {8'(7*i+3), 8'(i+9), 8'(11*i)});
      z = word(v[3], v[2], v[1], {8'(i+40), 8'(13*i+5), 8'(2*i+77)});
      step(x, y, z);
      check($sformatf("R1/R2/R10 vec%0d valid", i), 64'(vld), 64'(v[0]));
      if (v[0]) check($sformatf("R3 vec%0d data", i), pix, exp_pix(x, y, z));
    end

    // fresh start for directed frame
    #1 rst_n = 1'b0;
    #2 check("R9 reset mid-run", {62'd0, vld, serr}, 0);
    {inv_f, inv_l, inv_d, use_d} = 4'b0001;
    cx = '0; cy = '0; cz = '0;
    @(posedge clk); #1 rst_n = 1'b1;
    step3(word(0, 0, 0, 24'h0));

    step3(word(1, 0, 0, 24'h0));
    marks("R4 frame start", 1, 0, 0, 0);
    check("R7 lines at frame start", 64'(lcnt), 0);
    wa = word(1, 1, 1, 24'hA1A2A3);
    step3(wa);
    marks("R5 line start", 0, 0, 1, 0);
    check("R2 first beat", 64'(vld), 1);
    check("R6 first index", 64'(pcnt), 0);
    check("R3 first data", pix, exp_pix(wa, wa, wa));
    step3(word(1, 1, 0, 24'h555555));
    check("R2 dval gap", 64'(vld), 0);
    check("R3 hold on gap", pix, exp_pix(wa, wa, wa));
    wb = word(1, 1, 1, 24'hB0B1B2);
    step3(wb);
    check("R6 index after gap", 64'(pcnt), 1);
    step3(word(1, 0, 0, 24'h0));
    marks("R5 line end", 0, 0, 0, 1);
    check("R7 one line done", 64'(lcnt), 1);
    wc = word(1, 1, 1, 24'hC3C4C5);
    step3(wc);
    marks("R5 second line", 0, 0, 1, 0);
    check("R6 restart index", 64'(pcnt), 0);
    check("R7 line count in line", 64'(lcnt), 1);
    wd = word(1, 1, 1, 24'hD6D7D8);
    step3(wd);
    check("R6 second index", 64'(pcnt), 1);
    step3(word(0, 0, 0, 24'h0));
    marks("R4 frame end with line end", 0, 1, 0, 1);
    check("R7 two lines", 64'(lcnt), 2);
    check("R3 hold after frame", pix, exp_pix(wd, wd, wd));
    step3(word(0, 1, 1, 24'h0));
    marks("R5 line rise outside frame", 0, 0, 0, 0);
    check("R2 no frame", 64'(vld), 0);
    step3(word(0, 0, 0, 24'h0));
    marks("R5 line fall outside frame", 0, 0, 0, 0);
    step3(word(1, 0, 0, 24'h0));
    marks("R4 second frame", 1, 0, 0, 0);
    check("R7 cleared", 64'(lcnt), 0);

    // R8 mismatch handling
    step(word(1, 0, 0, 24'h0), word(0, 1, 1, 24'h0), word(1, 0, 0, 24'h0));
    check("R8 unqualified mismatch ignored", 64'(serr), 0);
    step(word(1, 1, 1, 24'h1), word(1, 1, 1, 24'h1), word(1, 1, 0, 24'h1));
    check("R8 qualified mismatch", 64'(serr), 1);
    step3(word(0, 0, 0, 24'h0));
    check("R8 sticky", 64'(serr), 1);

    // R10 data valid ignored
    use_d = 1'b0;
    step3(word(1, 0, 0, 24'h0));
    step3(word(1, 1, 0, 24'h123456));
    check("R10 dval low ignored", 64'(vld), 1);
    check("R6 index with dval ignored", 64'(pcnt), 0);
    step3(word(1, 1, 1, 24'h654321));
    check("R10 dval high ignored", 64'(vld), 1);
    check("R6 index next", 64'(pcnt), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule